// File: doc/BRIEF.md
# Indirect Interrupt Register Access Port

This block sits between a processor core's indirect register window and the storage of an interrupt file. Each request names a privilege level, a virtualisation flag, a guest-file index, an eight-bit register select code, a claim flag, an XLEN indication, a write value and a write mask. The block works out which page of the file is addressed, decides whether the access is legal, and performs a masked read-modify-write on one register of that page: the delivery-enable bit, the priority threshold, the claim register, or one word of pending or enable bits.

The storage and the priority logic live outside. The block drives a page, a register kind, a word index and a width flag towards the storage, takes the addressed register's current contents back combinationally, and issues a single-cycle write strobe with the merged value. One cycle after a request, a registered response returns the value the register held before the write, or an error flag.

A parameter chooses between a machine-level instance, which owns a single page, and a supervisor-level instance, which owns page 0 plus one page per guest.

Top module: `iaccess_port`

## Requirements
- R1: A non-virtualised request accepted by either instance targets page 0 (`filePage` = 0).
- R2: On a supervisor instance a virtualised supervisor request targets the page equal to `reqGuest`; a guest index of 0 or of `NUM_PAGES` or more is an error.
- R3: Privilege is encoded 3 = machine, 1 = supervisor. A machine instance (`MMODE`=1) accepts only privilege 3 with `reqVirt`=0; a supervisor instance accepts only privilege 1.
- R4: An illegal request (bad privilege/virtualisation/guest combination, unknown select code, bad word number) returns `rspErr`=1 and `rspData`=0 and raises no `fileWe`.
- R5: With `reqClaim`=0, select 0x70 is delivery-enable (`fileKind` 0), 0x72 is threshold (1), 0x80+n is pending word n (3), 0xC0+n is enable word n (4); any other code is unknown. `reqClaim`=1 selects the claim register (2) whatever the select code.
- R6: For non-claim registers the written value is (old & ~m) | (value & m), where m is the write mask limited to the register's field; `fileWe` is raised only when m is nonzero.
- R7: Every request gives `rspValid` exactly one cycle later; `rspData` is the register's field value before the write.
- R8: Delivery-enable is 1 bit wide and threshold `THR_BITS` bits wide; higher bits read as 0 and are never written.
- R9: With `reqWide`=1 (64-bit XLEN) an odd word number is an error and an even one is halved to form `fileWord`; with `reqWide`=0 the word number is used as is, and bits 63:32 read as 0 and are written as 0.
- R10: A word index at or beyond `NUM_IDS`/32 (narrow) or `NUM_IDS`/64 (wide) is an error.
- R11: Bit 0 of pending word 0 and of enable word 0 reads as 0, and a write to it alone raises no strobe.
- R12: A legal claim read returns the storage value unchanged; a legal claim write with any nonzero mask raises `fileWe` with `fileWdata` = 0, the value being ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqPriv | input | 2 | Privilege of the access (3 machine, 1 supervisor) |
| reqVirt | input | 1 | Access comes from a virtualised context |
| reqGuest | input | GUEST_W | Guest-file index for virtualised accesses |
| reqSel | input | 8 | Register select code |
| reqClaim | input | 1 | Access targets the claim register |
| reqWide | input | 1 | 64-bit XLEN when set, 32-bit otherwise |
| reqWdata | input | 64 | Write value |
| reqWmask | input | 64 | Write mask |
| filePage | output | PAGE_W | Page addressed in the storage |
| fileKind | output | 3 | Register kind (0 delivery, 1 threshold, 2 claim, 3 pending, 4 enable) |
| fileWord | output | 6 | Word index in XLEN units for pending/enable |
| fileWide | output | 1 | Word width for pending/enable (1 = 64 bits) |
| fileRdata | input | 64 | Current contents of the addressed register |
| fileWe | output | 1 | Write strobe to the storage |
| fileWdata | output | 64 | Merged value to store |
| rspValid | output | 1 | Response valid |
| rspData | output | 64 | Value before the write |
| rspErr | output | 1 | Request was illegal |

## Verification
The hardest situations to reach from the ports are the ones where several legality rules meet at once: a virtualised access with a guest index just past the last page, a wide access to an odd word that would otherwise be in range, and a narrow access to the last legal word next to the first illegal one. Directed requests place each of these at its exact boundary, and a fixed-seed random stream then mixes privileges, guest indices, select codes over the whole 8-bit range, both widths and sparse or full masks, so that legal and illegal cases alternate against a bench storage model seeded with bit 0 of word 0 set and with garbage above narrow fields.

// File: rtl/iaccess_pkg.sv
package iaccess_pkg;

  typedef enum logic [2:0] {
    KIND_DELIV  = 3'd0,
    KIND_THRESH = 3'd1,
    KIND_CLAIM  = 3'd2,
    KIND_PEND   = 3'd3,
    KIND_ENAB   = 3'd4
  } regKind_e;

  localparam logic [1:0] PRIV_SUP  = 2'd1;
  localparam logic [1:0] PRIV_MACH = 2'd3;

  localparam logic [7:0] SEL_DELIV  = 8'h70;
  localparam logic [7:0] SEL_THRESH = 8'h72;

  localparam int WORD_W = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic     legal;
    regKind_e kind;
    logic     wide;
    logic     lowWord;
  } ctrlStrb_t;

endpackage

// File: rtl/iaccess_ctrl.sv
module iaccess_ctrl
  import iaccess_pkg::*;
#(
  parameter bit MMODE     = 1'b0,
  parameter int NUM_PAGES = 4,
  parameter int NUM_IDS   = 128,
  parameter int GUEST_W   = 3,
  parameter int PAGE_W    = 2
) (
  input  logic               reqValid,
  input  logic [1:0]         reqPriv,
  input  logic               reqVirt,
  input  logic [GUEST_W-1:0] reqGuest,
  input  logic [7:0]         reqSel,
  input  logic               reqClaim,
  input  logic               reqWide,
  output ctrlStrb_t          strb,
  output logic [PAGE_W-1:0]  pageSel,
  output logic [WORD_W-1:0]  wordIdx
);

  localparam int WORDS_NARROW = NUM_IDS / 32;
  localparam int WORDS_WIDE   = NUM_IDS / 64;

  logic     pageOk;
  logic     selOk;
  logic     isEix;
  logic     wordOk;
  regKind_e kind;

  // page selection: the instance flavour picks the rule
  if (MMODE) begin : g_mach
    always_comb begin
      pageSel = '0;
      pageOk  = (reqPriv == PRIV_MACH) && !reqVirt;
    end
  end else begin : g_sup
    always_comb begin
      pageSel = '0;
      pageOk  = 1'b0;
      if (reqPriv == PRIV_SUP) begin
        if (!reqVirt) begin
          pageOk = 1'b1;
        end else if ((reqGuest != '0) && (32'(reqGuest) < NUM_PAGES)) begin
          pageOk  = 1'b1;
          pageSel = PAGE_W'(reqGuest);
        end
      end
    end
  end

  // register decode
  always_comb begin
    selOk = 1'b1;
    isEix = 1'b0;
    kind  = KIND_DELIV;
    if (reqClaim) begin
      kind = KIND_CLAIM;
    end else if (reqSel == SEL_DELIV) begin
      kind = KIND_DELIV;
    end else if (reqSel == SEL_THRESH) begin
      kind = KIND_THRESH;
    end else if (reqSel[7]) begin
      isEix = 1'b1;
      kind  = reqSel[6] ? KIND_ENAB : KIND_PEND;
    end else begin
      selOk = 1'b0;
    end
  end

  // word packing by XLEN
  always_comb begin
    wordIdx = reqWide ? {1'b0, reqSel[5:1]} : reqSel[5:0];
    if (!isEix) begin
      wordOk = 1'b1;
    end else if (reqWide) begin
      wordOk = !reqSel[0] && (32'(wordIdx) < WORDS_WIDE);
    end else begin
      wordOk = 32'(wordIdx) < WORDS_NARROW;
    end
  end

  always_comb begin
    strb.legal   = reqValid && pageOk && selOk && wordOk;
    strb.kind    = kind;
    strb.wide    = reqWide;
    strb.lowWord = isEix && (wordIdx == '0);
  end

endmodule

// File: rtl/iaccess_dp.sv
module iaccess_dp
  import iaccess_pkg::*;
#(
  parameter int THR_BITS = 11,
  parameter int DATA_W   = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] reqWmask,
  input  logic [DATA_W-1:0] fileRdata,
  output logic              fileWe,
  output logic [DATA_W-1:0] fileWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspErr
);

  localparam logic [DATA_W-1:0] THR_MASK    = (DATA_W'(1) << THR_BITS) - DATA_W'(1);
  localparam logic [DATA_W-1:0] NARROW_MASK = DATA_W'(32'hFFFF_FFFF);

  logic [DATA_W-1:0] fieldMask;
  logic [DATA_W-1:0] oldVal;
  logic [DATA_W-1:0] effMask;
  logic [DATA_W-1:0] mergedVal;
  logic              isClaim;

  always_comb begin
    unique case (strb.kind)
      KIND_DELIV:  fieldMask = DATA_W'(1);
      KIND_THRESH: fieldMask = THR_MASK;
      KIND_CLAIM:  fieldMask = '1;
      default:     fieldMask = strb.wide ? '1 : NARROW_MASK;
    endcase
    if (strb.lowWord) fieldMask[0] = 1'b0;
  end

  always_comb begin
    isClaim   = (strb.kind == KIND_CLAIM);
    oldVal    = fileRdata & fieldMask;
    effMask   = reqWmask & fieldMask;
    mergedVal = (oldVal & ~effMask) | (reqWdata & effMask);
    fileWe    = strb.legal && (isClaim ? (reqWmask != '0) : (effMask != '0));
    fileWdata = isClaim ? '0 : mergedVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= reqValid;
      rspErr   <= reqValid && !strb.legal;
      rspData  <= strb.legal ? oldVal : '0;
    end
  end

endmodule

// File: rtl/iaccess_port.sv
module iaccess_port
  import iaccess_pkg::*;
#(
  parameter bit MMODE     = 1'b0,
  parameter int NUM_PAGES = 4,
  parameter int NUM_IDS   = 128,
  parameter int THR_BITS  = 11,
  parameter int GUEST_W   = 3,
  parameter int PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [1:0]         reqPriv,
  input  logic               reqVirt,
  input  logic [GUEST_W-1:0] reqGuest,
  input  logic [7:0]         reqSel,
  input  logic               reqClaim,
  input  logic               reqWide,
  input  logic [63:0]        reqWdata,
  input  logic [63:0]        reqWmask,
  output logic [PAGE_W-1:0]  filePage,
  output logic [2:0]         fileKind,
  output logic [5:0]         fileWord,
  output logic               fileWide,
  input  logic [63:0]        fileRdata,
  output logic               fileWe,
  output logic [63:0]        fileWdata,
  output logic               rspValid,
  output logic [63:0]        rspData,
  output logic               rspErr
);

  ctrlStrb_t strb;

  iaccess_ctrl #(
    .MMODE(MMODE), .NUM_PAGES(NUM_PAGES), .NUM_IDS(NUM_IDS),
    .GUEST_W(GUEST_W), .PAGE_W(PAGE_W)
  ) u_ctrl (
    .reqValid(reqValid), .reqPriv(reqPriv), .reqVirt(reqVirt),
    .reqGuest(reqGuest), .reqSel(reqSel), .reqClaim(reqClaim),
    .reqWide(reqWide), .strb(strb), .pageSel(filePage), .wordIdx(fileWord)
  );

  iaccess_dp #(.THR_BITS(THR_BITS), .DATA_W(64)) u_dp (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .strb(strb),
    .reqWdata(reqWdata), .reqWmask(reqWmask), .fileRdata(fileRdata),
    .fileWe(fileWe), .fileWdata(fileWdata),
    .rspValid(rspValid), .rspData(rspData), .rspErr(rspErr)
  );

  assign fileKind = strb.kind;
  assign fileWide = reqWide;

endmodule

// File: rtl/iaccess_chk.sv
module iaccess_chk #(
  parameter bit MMODE     = 1'b0,
  parameter int NUM_PAGES = 4,
  parameter int GUEST_W   = 3,
  parameter int PAGE_W    = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [1:0]         reqPriv,
  input logic               reqVirt,
  input logic [GUEST_W-1:0] reqGuest,
  input logic [PAGE_W-1:0]  filePage,
  input logic [2:0]         fileKind,
  input logic [5:0]         fileWord,
  input logic               fileWide,
  input logic               fileWe,
  input logic [63:0]        fileWdata,
  input logic               rspValid,
  input logic               rspErr
);

  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R7
  AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R7
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && fileWe) |=> !rspErr); // R4
  AST_WRITE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    fileWe |-> reqValid); // R6
  AST_DIRECT_PAGE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (fileWe && !reqVirt) |-> (filePage == '0)); // R1
  AST_GUEST_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    (fileWe && reqVirt) |-> ((32'(filePage) == 32'(reqGuest)) && (reqGuest != '0)
                             && (32'(reqGuest) < NUM_PAGES))); // R2
  AST_MACH_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    fileWe |-> (MMODE ? (reqPriv == 2'd3 && !reqVirt) : (reqPriv == 2'd1))); // R3
  AST_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (fileWe && (fileKind == 3'd3 || fileKind == 3'd4) && fileWord == 6'd0)
      |-> !fileWdata[0]); // R11
  AST_DELIV_ONE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (fileWe && fileKind == 3'd0) |-> (fileWdata[63:1] == '0)); // R8
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (fileWe && !fileWide && (fileKind == 3'd3 || fileKind == 3'd4))
      |-> (fileWdata[63:32] == '0)); // R9

endmodule

bind iaccess_port iaccess_chk #(
  .MMODE(MMODE), .NUM_PAGES(NUM_PAGES), .GUEST_W(GUEST_W), .PAGE_W(PAGE_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPriv(reqPriv),
  .reqVirt(reqVirt), .reqGuest(reqGuest), .filePage(filePage),
  .fileKind(fileKind), .fileWord(fileWord), .fileWide(fileWide),
  .fileWe(fileWe), .fileWdata(fileWdata), .rspValid(rspValid), .rspErr(rspErr)
);

// File: tb/tb_iaccess_port.sv
module tb_iaccess_port;

  localparam int NP   = 4;
  localparam int NIDS = 128;
  localparam int THR  = 11;
  localparam int GW   = 3;
  localparam int PW   = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic          reqValid = 1'b0;
  logic [1:0]    reqPriv = '0;
  logic          reqVirt = 1'b0;
  logic [GW-1:0] reqGuest = '0;
  logic [7:0]    reqSel = '0;
  logic          reqClaim = 1'b0;
  logic          reqWide = 1'b0;
  logic [63:0]   reqWdata = '0;
  logic [63:0]   reqWmask = '0;

  logic [PW-1:0] filePage;
  logic [2:0]    fileKind;
  logic [5:0]    fileWord;
  logic          fileWide;
  logic [63:0]   fileRdata;
  logic          fileWe;
  logic [63:0]   fileWdata;
  logic          rspValid;
  logic [63:0]   rspData;
  logic          rspErr;

  logic [PW-1:0] mPage;
  logic [2:0]    mKind;
  logic [5:0]    mWord;
  logic          mWide;
  logic          mWe;
  logic [63:0]   mWdata;
  logic          mRspValid;
  logic [63:0]   mRspData;
  logic          mRspErr;

  iaccess_port #(.MMODE(1'b0), .NUM_PAGES(NP), .NUM_IDS(NIDS), .THR_BITS(THR),
                 .GUEST_W(GW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPriv(reqPriv),
    .reqVirt(reqVirt), .reqGuest(reqGuest), .reqSel(reqSel), .reqClaim(reqClaim),
    .reqWide(reqWide), .reqWdata(reqWdata), .reqWmask(reqWmask),
    .filePage(filePage), .fileKind(fileKind), .fileWord(fileWord),
    .fileWide(fileWide), .fileRdata(fileRdata), .fileWe(fileWe),
    .fileWdata(fileWdata), .rspValid(rspValid), .rspData(rspData), .rspErr(rspErr)
  );

  // machine-level instance, storage reads as zero
  iaccess_port #(.MMODE(1'b1), .NUM_PAGES(NP), .NUM_IDS(NIDS), .THR_BITS(THR),
                 .GUEST_W(GW)) dutMach (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqPriv(reqPriv),
    .reqVirt(reqVirt), .reqGuest(reqGuest), .reqSel(reqSel), .reqClaim(reqClaim),
    .reqWide(reqWide), .reqWdata(reqWdata), .reqWmask(reqWmask),
    .filePage(mPage), .fileKind(mKind), .fileWord(mWord),
    .fileWide(mWide), .fileRdata(64'd0), .fileWe(mWe),
    .fileWdata(mWdata), .rspValid(mRspValid), .rspData(mRspData), .rspErr(mRspErr)
  );

  // storage model
  logic            mDeliv [NP];
  logic [THR-1:0]  mThr   [NP];
  logic [NIDS-1:0] mPend  [NP];
  logic [NIDS-1:0] mEnab  [NP];
  logic [63:0]     mClaim [NP];

  localparam logic [63:0] JUNK = 64'hA5A5_0000_0000_0000;

  always_comb begin
    logic [NIDS-1:0] bits;
    bits = (fileKind == 3'd4) ? mEnab[filePage] : mPend[filePage];
    fileRdata = '0;
    case (fileKind)
      3'd0: fileRdata = JUNK | 64'(mDeliv[filePage]);
      3'd1: fileRdata = JUNK | 64'(mThr[filePage]);
      3'd2: fileRdata = mClaim[filePage];
      3'd3, 3'd4: begin
        if (fileWide && 32'(fileWord) < NIDS / 64)
          fileRdata = bits[32'(fileWord) * 64 +: 64];
        else if (!fileWide && 32'(fileWord) < NIDS / 32)
          fileRdata = {32'hDEAD_BEEF, bits[32'(fileWord) * 32 +: 32]};
      end
      default: fileRdata = '0;
    endcase
  end

  always @(posedge clk) begin
    if (fileWe) begin
      case (fileKind)
        3'd0: mDeliv[filePage] <= fileWdata[0];
        3'd1: mThr[filePage] <= fileWdata[THR-1:0];
        3'd3: if (fileWide) mPend[filePage][32'(fileWord) * 64 +: 64] <= fileWdata;
              else mPend[filePage][32'(fileWord) * 32 +: 32] <= fileWdata[31:0];
        3'd4: if (fileWide) mEnab[filePage][32'(fileWord) * 64 +: 64] <= fileWdata;
              else mEnab[filePage][32'(fileWord) * 32 +: 32] <= fileWdata[31:0];
        default: ;
      endcase
    end
  end

  int nChecks = 0;
  int nErrors = 0;
  bit finished = 1'b0;

  task automatic chk(input logic ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // expected old field value from the model (only meaningful when legal)
  function automatic logic [63:0] expOld(input logic [2:0] k, input int pg,
                                         input int idx, input logic wide);
    logic [63:0] v;
    logic [NIDS-1:0] bits;
    bits = (k == 3'd4) ? mEnab[pg] : mPend[pg];
    case (k)
      3'd0: v = 64'(mDeliv[pg]);
      3'd1: v = 64'(mThr[pg]);
      3'd2: v = mClaim[pg];
      default: v = wide ? bits[idx * 64 +: 64] : 64'(bits[idx * 32 +: 32]);
    endcase
    if ((k == 3'd3 || k == 3'd4) && idx == 0) v[0] = 1'b0;
    return v;
  endfunction

  task automatic doReq(input logic [1:0] priv, input logic virt, input logic [GW-1:0] guest,
                       input logic [7:0] sel, input logic claim, input logic wide,
                       input logic [63:0] wd, input logic [63:0] wm);
    logic pOk, mOk, sOk, eix, wOk, legal, mLegal, expWe;
    logic [2:0] kind;
    int pg, idx;
    logic [63:0] old, fm, em, expData;
    pOk = (priv == 2'd1) && (!virt || (guest != 0 && int'(guest) < NP));
    mOk = (priv == 2'd3) && !virt;
    pg  = (pOk && virt) ? int'(guest) : 0;
    sOk = 1'b1; eix = 1'b0; kind = 3'd0;
    if (claim) kind = 3'd2;
    else if (sel == 8'h70) kind = 3'd0;
    else if (sel == 8'h72) kind = 3'd1;
    else if (sel >= 8'h80) begin eix = 1'b1; kind = (sel >= 8'hC0) ? 3'd4 : 3'd3; end
    else sOk = 1'b0;
    idx = wide ? int'(sel[5:0]) / 2 : int'(sel[5:0]);
    wOk = !eix || (wide ? (!sel[0] && idx < NIDS / 64) : (idx < NIDS / 32));
    legal  = pOk && sOk && wOk;
    mLegal = mOk && sOk && wOk;
    old = legal ? expOld(kind, pg, idx, wide) : 64'd0;
    case (kind)
      3'd0: fm = 64'd1;
      3'd1: fm = (64'd1 << THR) - 64'd1;
      3'd2: fm = '1;
      default: fm = wide ? '1 : 64'hFFFF_FFFF;
    endcase
    if (eix && idx == 0) fm[0] = 1'b0;
    em = wm & fm;
    expWe = legal && ((kind == 3'd2) ? (wm != 0) : (em != 0));
    expData = (kind == 3'd2) ? 64'd0 : ((old & ~em) | (wd & em));

    @(negedge clk);
    reqValid = 1'b1; reqPriv = priv; reqVirt = virt; reqGuest = guest;
    reqSel = sel; reqClaim = claim; reqWide = wide; reqWdata = wd; reqWmask = wm;
    #2;
    chk(fileWe == expWe, "R6 strobe", 64'(fileWe), 64'(expWe));
    if (expWe) begin
      chk(fileWdata == expData, "R6 merged data", fileWdata, expData);
      chk(int'(filePage) == pg, "R2 page", 64'(filePage), 64'(pg));
      chk(fileKind == kind, "R5 kind", 64'(fileKind), 64'(kind));
    end
    @(posedge clk);
    @(negedge clk);
    chk(rspValid == 1'b1, "R7 valid", 64'(rspValid), 64'd1);
    chk(rspErr == !legal, "R4 error", 64'(rspErr), 64'(!legal));
    chk(rspData == old, "R7 old value", rspData, old);
    chk(mRspErr == !mLegal, "R3 machine error", 64'(mRspErr), 64'(!mLegal));
    reqValid = 1'b0;
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin
      mDeliv[p] = 1'b0;
      mThr[p] = '0;
      mPend[p] = '0;
      mEnab[p] = '0;
      mPend[p][0] = 1'b1;
      mEnab[p][0] = 1'b1;
      mClaim[p] = 64'h0000_0000_0007_0007 + 64'(p);
    end
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // reset state (R7)
    chk(!rspValid && !rspErr && rspData == 0, "R7 reset", rspData, 64'd0);
    chk(!fileWe, "R6 reset strobe", 64'(fileWe), 64'd0);

    // R1: direct supervisor access to page 0
    doReq(2'd1, 1'b0, 3'd0, 8'h70, 1'b0, 1'b0, 64'd1, 64'd1);
    doReq(2'd1, 1'b0, 3'd2, 8'h70, 1'b0, 1'b0, 64'd0, 64'd0);
    // R8: field widths of delivery and threshold
    doReq(2'd1, 1'b0, 3'd0, 8'h72, 1'b0, 1'b0, '1, '1);
    doReq(2'd1, 1'b0, 3'd0, 8'h72, 1'b0, 1'b0, 64'd0, 64'h0F0);
    doReq(2'd1, 1'b0, 3'd0, 8'h70, 1'b0, 1'b0, '1, '1);
    // R2: guest pages and their limits
    doReq(2'd1, 1'b1, 3'd2, 8'h72, 1'b0, 1'b0, 64'd5, '1);
    doReq(2'd1, 1'b1, 3'd3, 8'h72, 1'b0, 1'b0, 64'd9, '1);
    doReq(2'd1, 1'b1, 3'd0, 8'h72, 1'b0, 1'b0, 64'd3, '1);
    doReq(2'd1, 1'b1, 3'd4, 8'h72, 1'b0, 1'b0, 64'd3, '1);
    doReq(2'd1, 1'b1, 3'd2, 8'h72, 1'b0, 1'b0, 64'd0, 64'd0);
    // R3, R4: wrong privilege, unknown select codes leave state alone
    doReq(2'd3, 1'b0, 3'd0, 8'h70, 1'b0, 1'b0, 64'd0, '1);
    doReq(2'd0, 1'b0, 3'd0, 8'h72, 1'b0, 1'b0, 64'd0, '1);
    doReq(2'd3, 1'b1, 3'd1, 8'h70, 1'b0, 1'b0, 64'd0, '1);
    doReq(2'd1, 1'b0, 3'd0, 8'h71, 1'b0, 1'b0, 64'd0, '1);
    doReq(2'd1, 1'b0, 3'd0, 8'h10, 1'b0, 1'b0, 64'd0, '1);
    doReq(2'd1, 1'b0, 3'd0, 8'h70, 1'b0, 1'b0, 64'd0, 64'd0);
    // R5, R9, R10: word packing and ranges
    doReq(2'd1, 1'b0, 3'd0, 8'h81, 1'b0, 1'b1, '1, '1);
    doReq(2'd1, 1'b0, 3'd0, 8'h82, 1'b0, 1'b1, 64'hFFFF_0000_1234_5678, '1);
    doReq(2'd1, 1'b0, 3'd0, 8'h83, 1'b0, 1'b0, '1, '1);
    doReq(2'd1, 1'b0, 3'd0, 8'h82, 1'b0, 1'b0, 64'd0, 64'd0);
    doReq(2'd1, 1'b0, 3'd0, 8'h84, 1'b0, 1'b0, '1, '1);
    doReq(2'd1, 1'b0, 3'd0, 8'h84, 1'b0, 1'b1, '1, '1);
    doReq(2'd1, 1'b0, 3'd0, 8'hC3, 1'b0, 1'b0, 64'hFFFF_FFFF_0000_00F0, 64'hFFFF_FFFF_0000_0FF0);
    // R11: bit 0 of word 0 is read-only zero
    doReq(2'd1, 1'b0, 3'd0, 8'h80, 1'b0, 1'b0, 64'd1, 64'd1);
    doReq(2'd1, 1'b0, 3'd0, 8'hC0, 1'b0, 1'b1, '1, '1);
    doReq(2'd1, 1'b0, 3'd0, 8'hC0, 1'b0, 1'b1, 64'd0, 64'd0);
    // R12: claim read and claim write
    doReq(2'd1, 1'b1, 3'd3, 8'h00, 1'b1, 1'b0, 64'd0, 64'd0);
    doReq(2'd1, 1'b0, 3'd0, 8'h55, 1'b1, 1'b1, 64'h1234, 64'd4);
    // R3: machine instance accepts machine privilege
    doReq(2'd3, 1'b0, 3'd0, 8'h80, 1'b0, 1'b0, 64'd2, 64'd2);

    // random mix
    for (int i = 0; i < 500; i++) begin
      logic [1:0] pr;
      logic [7:0] sl;
      logic [63:0] wm;
      int r;
      r = int'($urandom_range(0, 4));
      pr = (r == 0) ? 2'd0 : (r == 4) ? 2'd3 : 2'd1;
      r = int'($urandom_range(0, 3));
      case (r)
        0: sl = $urandom_range(0, 1) ? 8'h70 : 8'h72;
        1: sl = 8'h80 | 8'($urandom_range(0, 7));
        2: sl = 8'hC0 | 8'($urandom_range(0, 7));
        default: sl = 8'($urandom);
      endcase
      r = int'($urandom_range(0, 3));
      wm = (r == 0) ? 64'd0 : (r == 1) ? '1 : {$urandom, $urandom};
      doReq(pr, 1'($urandom), GW'($urandom), sl, $urandom_range(0, 9) == 0,
            1'($urandom), {$urandom, $urandom}, wm);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

endmodule